// File: doc/BRIEF.md
# ECC-Protected Synchronous FIFO

A single-clock first-in first-out buffer whose stored words carry an error-correcting code. Each word accepted on the write side is padded to 32 bits, encoded into a 44-bit codeword and kept in an internal array. On the way out the codeword is decoded. The read result comes back together with a 2-bit status saying whether the word was clean, was repaired, or could not be repaired.

The code is built from two interleaved lanes. Each lane is an extended Hamming code over 16 data bits. Neighbouring codeword bits always fall into different lanes. As a result, one flipped bit or two flipped neighbours are repaired, and three flipped neighbours leave one lane with a double error, which is flagged. Repair touches only the output, never the stored word. A test input XORs a mask into the codeword as it is written, so faults can be placed at exact bit positions.

Top module: `ecc_sync_fifo`

## Requirements
- R1: Words leave in the order they were accepted. A read is accepted when rd_en is high at a rising edge while the FIFO is not empty. After that edge rd_valid is high for one cycle, and rd_data and ecc_status describe the word read.
- R2: After reset empty is 1 and full is 0. full is 1 exactly when DEPTH words are held, empty is 1 exactly when none are held, and the two are never both 1.
- R3: A write request while full is dropped. The stored contents and their order are unchanged, even when a read is accepted in the same cycle.
- R4: A read request while empty is dropped. rd_valid stays 0 and ecc_status stays 00 on the next cycle. A write in the same cycle is still accepted.
- R5: ecc_status is 00 for a clean word, 10 for a repaired word and 11 for an unrepairable word. The value 01 never appears, and the status is 00 in every cycle that follows an edge with no accepted read.
- R6: A single flipped bit at any of the 44 codeword positions gives the original data with status 10.
- R7: Two flipped bits at any adjacent pair of codeword positions give the original data with status 10.
- R8: Three flipped bits at any three adjacent codeword positions give status 11. In that case rd_data is the data taken from the stored codeword without repair.
- R9: Codeword layout. Codeword bit 2k+l is bit k of lane l, where lane 0 carries padded data bits 15:0 and lane 1 carries bits 31:16. Within a lane, bit 0 is the overall parity and bits 1, 2, 4, 8 and 16 are check bits. Data bit j of the lane sits at the j-th remaining position in ascending order: 3, 5, 6, 7, 9 to 15, 17 to 21.
- R10: With DATA_W below 32, the unused upper bits are set to 1 before encoding. rd_data returns the low DATA_W bits with the same repair and status behaviour.
- R11: inj_mask is XORed into a codeword only when a write is accepted. A mask presented without an accepted write has no effect on any stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| inj_mask | input | 44 | Bits XORed into the codeword on an accepted write (test use) |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | High for the cycle after an accepted read |
| rd_data | output | DATA_W | Repaired data, or unrepaired data when status is 11 |
| ecc_status | output | 2 | 00 clean, 10 repaired, 11 unrepairable |
| full | output | 1 | DEPTH words held |
| empty | output | 1 | No word held |

## Verification
The bench sweeps every single, adjacent-pair and adjacent-triple fault position, including the edge bits 0 and 43. A wrong interleave or check position shows up there as a mis-repair, or as a triple quietly reported as repaired. For triples it compares the full unrepaired data, so a design that still patches a lane it has declared bad returns the wrong word. It also pushes write-when-full and read-when-empty, each combined with the opposite request. A design that moves a pointer there loses or duplicates a word. Masks presented while no write is accepted must leave later words clean. A narrow-data instance confirms that padding and truncation do not disturb repair.

// File: rtl/ecc_sync_fifo.sv
module ecc_sync_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int CW_W  = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CW_W-1:0]   inj_mask,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        ecc_status,
  output logic              full,
  output logic              empty
);
  localparam int LW    = 22;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [1:0] ST_OK  = 2'b00;
  localparam logic [1:0] ST_FIX = 2'b10;
  localparam logic [1:0] ST_BAD = 2'b11;

  // lane position of the j-th data bit: skips 0 and powers of two
  function automatic int dpos(input int j);
    int c, r;
    c = 0;
    r = 0;
    for (int p = 3; p < LW; p++)
      if ((p & (p - 1)) != 0) begin
        if (c == j) r = p;
        c++;
      end
    return r;
  endfunction

  function automatic logic [CW_W-1:0] encode(input logic [31:0] d);
    logic [LW-1:0]   ln;
    logic [CW_W-1:0] cw;
    cw = '0;
    for (int l = 0; l < 2; l++) begin
      ln = '0;
      for (int j = 0; j < 16; j++) ln[dpos(j)] = d[16*l + j];
      for (int b = 0; b < 5; b++)
        for (int p = 3; p < LW; p++)
          if (p[b] && ((p & (p - 1)) != 0)) ln[1 << b] = ln[1 << b] ^ ln[p];
      ln[0] = ^ln[LW-1:1];
      for (int k = 0; k < LW; k++) cw[2*k + l] = ln[k];
    end
    return cw;
  endfunction

  function automatic logic [33:0] decode(input logic [CW_W-1:0] cw);
    logic [LW-1:0] ln;
    logic [4:0]    s;
    logic          bad, fix;
    logic [31:0]   dc, dr;
    bad = 1'b0;
    fix = 1'b0;
    dc  = '0;
    dr  = '0;
    for (int l = 0; l < 2; l++) begin
      for (int k = 0; k < LW; k++) ln[k] = cw[2*k + l];
      for (int j = 0; j < 16; j++) dr[16*l + j] = ln[dpos(j)];
      s = '0;
      for (int k = 1; k < LW; k++) if (ln[k]) s = s ^ 5'(k);
      if (^ln) begin
        fix = 1'b1;
        if (int'(s) < LW) ln[s] = ~ln[s];
        else bad = 1'b1;
      end else if (s != '0) begin
        bad = 1'b1;
      end
      for (int j = 0; j < 16; j++) dc[16*l + j] = ln[dpos(j)];
    end
    if (bad) return {ST_BAD, dr};
    if (fix) return {ST_FIX, dc};
    return {ST_OK, dc};
  endfunction

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [CW_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             do_wr, do_rd;
  logic [33:0]      dec;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign dec   = decode(mem[rptr]);

  always_ff @(posedge clk)
    if (do_wr) mem[wptr] <= encode(~32'(~wr_data)) ^ inj_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      count      <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      ecc_status <= ST_OK;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      count      <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
      rd_valid   <= do_rd;
      ecc_status <= do_rd ? dec[33:32] : ST_OK;
      if (do_rd) rd_data <= dec[DATA_W-1:0];
    end

  assert_status_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_status != 2'b01);
  assert_idle_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !empty) |=> (ecc_status == ST_OK && !rd_valid));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (full && $stable(wptr)));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> (empty && $stable(rptr)));
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: tb/ecc_sync_fifo_tb_top.sv
`timescale 1ns/1ps
module ecc_sync_fifo_tb_top;
  localparam int DEPTH = 512;
  localparam int NDEP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [43:0] inj_mask = '0;
  logic        rd_valid, full, empty;
  logic [31:0] rd_data;
  logic [1:0]  ecc_status;

  logic        n_wr = 0, n_rd = 0;
  logic [19:0] n_wd = '0;
  logic [43:0] n_mask = '0;
  logic        n_valid, n_full, n_empty;
  logic [19:0] n_data;
  logic [1:0]  n_stat;

  ecc_sync_fifo #(.DATA_W(32), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .inj_mask(inj_mask),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .ecc_status(ecc_status),
    .full(full), .empty(empty));

  ecc_sync_fifo #(.DATA_W(20), .DEPTH(NDEP)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .wr_en(n_wr), .wr_data(n_wd), .inj_mask(n_mask),
    .rd_en(n_rd), .rd_valid(n_valid), .rd_data(n_data), .ecc_status(n_stat),
    .full(n_full), .empty(n_empty));

  int checks = 0, failures = 0, cnt = 0;
  logic [31:0] qd[$];
  logic [1:0]  qs[$];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic int lane_pos(input int j);
    if (j == 0) return 3;
    if (j < 4) return j + 4;
    if (j < 11) return j + 5;
    return j + 6;
  endfunction

  function automatic logic [43:0] mk(input int nbits, input int pos);
    logic [43:0] m;
    m = '0;
    for (int i = 0; i < nbits; i++) m[pos + i] = 1'b1;
    return m;
  endfunction

  function automatic logic [1:0] exp_stat(input logic [43:0] m);
    if (m == '0) return 2'b00;
    if ($countones(m) == 3) return 2'b11;
    return 2'b10;
  endfunction

  function automatic logic [31:0] exp_val(input logic [31:0] pad, input logic [43:0] m);
    logic [31:0] r;
    if (exp_stat(m) != 2'b11) return pad;
    for (int i = 0; i < 32; i++) r[i] = pad[i] ^ m[2*lane_pos(i % 16) + i / 16];
    return r;
  endfunction

  task automatic step(input logic we, input logic [31:0] wd, input logic [43:0] m,
                      input logic re, input string rq);
    logic aw, ar;
    logic [31:0] ed;
    logic [1:0]  es;
    chk(full === (cnt == DEPTH), {"R2 full ", rq}, 64'(full), 64'(cnt == DEPTH));
    chk(empty === (cnt == 0), {"R2 empty ", rq}, 64'(empty), 64'(cnt == 0));
    wr_en = we; wr_data = wd; inj_mask = m; rd_en = re;
    ar = re && (cnt > 0);
    aw = we && (cnt < DEPTH);
    ed = '0;
    es = 2'b00;
    if (ar) begin
      ed = qd.pop_front();
      es = qs.pop_front();
    end
    if (aw) begin
      qd.push_back(exp_val(wd, m));
      qs.push_back(exp_stat(m));
    end
    cnt = cnt + int'(aw) - int'(ar);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; inj_mask = '0;
    chk(rd_valid === ar, {"R1 valid ", rq}, 64'(rd_valid), 64'(ar));
    chk(ecc_status === es, {"R5 status ", rq}, 64'(ecc_status), 64'(es));
    if (ar) chk(rd_data === ed, {"R1 data ", rq}, 64'(rd_data), 64'(ed));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [19:0] nwd [4];
    logic [43:0] nm  [4];
    logic [31:0] ev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty === 1'b1 && full === 1'b0, "R2 reset flags", {full, empty}, 2'b01);
    chk(rd_valid === 1'b0 && ecc_status === 2'b00, "R5 reset status", {rd_valid, ecc_status}, 0);

    for (int i = 0; i < 8; i++) step(1, $urandom, '0, 0, "R5 clean");
    for (int i = 0; i < 8; i++) step(0, '0, '0, 1, "R5 clean");

    for (int p = 0; p < 44; p++) step(1, $urandom, mk(1, p), 0, "R6");
    for (int p = 0; p < 44; p++) step(0, '0, '0, 1, "R6");
    for (int p = 0; p < 43; p++) step(1, $urandom, mk(2, p), 0, "R7");
    for (int p = 0; p < 43; p++) step(0, '0, '0, 1, "R7");
    for (int p = 0; p < 42; p++) step(1, $urandom, mk(3, p), 0, "R8 R9");
    for (int p = 0; p < 42; p++) step(0, '0, '0, 1, "R8 R9");

    step(0, $urandom, mk(1, 5), 0, "R11");
    step(0, $urandom, mk(3, 20), 0, "R11");
    step(1, $urandom, '0, 0, "R11");
    step(0, '0, mk(2, 9), 1, "R11");

    while (cnt < DEPTH) step(1, $urandom, '0, 0, "R2 fill");
    step(1, $urandom, mk(1, 3), 0, "R3 write when full");
    step(1, $urandom, '0, 1, "R3 write and read when full");
    step(1, $urandom, '0, 0, "R3 refill");
    while (cnt > 0) step(0, '0, '0, 1, "R3 drain");
    step(0, '0, '0, 1, "R4 read when empty");
    step(1, $urandom, '0, 1, "R4 read and write when empty");
    step(0, '0, '0, 1, "R4 drain");

    for (int i = 0; i < 4000; i++) begin
      int wp, k;
      wp = (i / 500) % 3 == 0 ? 80 : ((i / 500) % 3 == 1 ? 50 : 20);
      k  = $urandom % 4;
      step(($urandom % 100) < wp, $urandom, mk(k, $urandom % (45 - (k == 0 ? 1 : k))),
           ($urandom % 100) < (100 - wp), "R1 random");
    end
    while (cnt > 0) step(0, '0, '0, 1, "R1 final drain");

    nm[0] = '0; nm[1] = mk(1, 10); nm[2] = mk(2, 6); nm[3] = mk(3, 6);
    for (int i = 0; i < 4; i++) begin
      nwd[i] = 20'($urandom);
      n_wr = 1; n_wd = nwd[i]; n_mask = nm[i];
      @(posedge clk);
      @(negedge clk);
    end
    n_wr = 0; n_mask = '0;
    chk(n_full === 1'b1 && n_empty === 1'b0, "R10 narrow full", {n_full, n_empty}, 2'b10);
    for (int i = 0; i < 4; i++) begin
      n_rd = 1;
      @(posedge clk);
      @(negedge clk);
      n_rd = 0;
      ev = exp_val({12'hFFF, nwd[i]}, nm[i]);
      chk(n_valid === 1'b1, "R10 narrow valid", 64'(n_valid), 1);
      chk(n_stat === exp_stat(nm[i]), "R10 narrow status", 64'(n_stat), 64'(exp_stat(nm[i])));
      chk(n_data === ev[19:0], "R10 narrow data", 64'(n_data), 64'(ev[19:0]));
    end
    chk(n_empty === 1'b1, "R10 narrow empty", 64'(n_empty), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule